// File: doc/BRIEF.md
# Delayed-Update LMS Adaptive Transversal Filter

This block is a sample-rate adaptive FIR filter. Each accepted sample carries an input `x` and a desired response `d`. The block returns the filter output `y` and the prediction error `e = d - y`. The coefficients learn by least-mean-squares. The error and the input that steer the learning are deliberately `ADAPT_DLY` samples old, and an optional holdup of `HOLD_DLY` samples retards both the filter input and the desired response. With both delays at zero the recursion is plain LMS. A larger adaptation delay slows convergence, so the delay is a parameter and is never made longer than requested.

All arithmetic is signed two's complement with bit-exact rounding behaviour. The block therefore serves as the behavioural reference against which a folded or pipelined implementation is compared sample by sample.

Data samples use `DW` bits. A coefficient is held in `AW` bits with `CFRAC` fractional bits relative to the data scale. The step size is a power of two, applied as an arithmetic right shift by `MU_SHIFT` of the error-times-input product, counted in coefficient LSBs.

Top module: `lms_dlms`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears every coefficient, every stored input, desired and error sample, `y_out`, `e_out` and `out_valid`. As a result, the first sample accepted after reset yields `y_out` = 0.
- R2: For a sample accepted at an edge (`in_valid` high), `y_out` after that edge equals floor((sum over k=0..TAPS-1 of c_k · x(n-k-HOLD_DLY)) / 2^CFRAC), clipped to the signed `DW`-bit range. Here c_k are the coefficients before this sample's update, and x(n) is the current input.
- R3: In the same cycle, `e_out` equals d(n-HOLD_DLY) - `y_out`, clipped to the signed `DW`-bit range.
- R4: At each accepted sample, every coefficient becomes c_k + ((e(n-ADAPT_DLY) · x(n-k-ADAPT_DLY-HOLD_DLY)) >>> MU_SHIFT), where >>> is an arithmetic shift (floor). Error and input samples older than the first post-reset sample count as zero.
- R5: A coefficient whose update would leave the signed `AW`-bit range is held at the nearest bound instead of wrapping.
- R6: In a cycle with `in_valid` low, the coefficients, all stored samples, `y_out` and `e_out` keep their values, whatever `x_in` and `d_in` carry.
- R7: With `ADAPT_DLY` = 0 and `HOLD_DLY` = 0, the update uses the current error and the current input window, so the filter performs exactly standard LMS.
- R8: `out_valid` is high for exactly the one cycle after each edge that accepts a sample, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe; high accepts `x_in` and `d_in` this edge |
| x_in | input | DW | Filter input sample, signed |
| d_in | input | DW | Desired response sample, signed |
| y_out | output | DW | Registered filter output, signed |
| e_out | output | DW | Registered error, signed |
| out_valid | output | 1 | High one cycle after each accepted sample |

## Verification
`y_out`, `e_out` and `out_valid` for a sample are registered on the same edge that accepts it, so they are due one cycle after the strobe. The bench drives each sample at a falling edge and checks the previous sample's results at the next falling edge, both for back-to-back strobes and for strobes separated by idle cycles.

The adapted coefficients show up only in later outputs. They are therefore checked against a bench model that runs both delay configurations side by side. Any update that arrives one sample early or late, or that uses the wrong input tap, shifts every subsequent output.

// File: rtl/lms_pkg.sv
// Shared helpers for the delayed-update LMS filter.
// Assumes every width used with clip() is between 2 and 63 bits.
package lms_pkg;

    // Clamp a signed value into the signed range of a w-bit word.
    function automatic longint clip(input longint v, input int w);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -hi - 1;
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/lms_delay_line.sv
// Sample-enabled delay line: dout is the din accepted LEN strobes ago.
// LEN = 0 makes it a plain wire. Storage clears on reset.
module lms_delay_line #(
    parameter int DW  = 16,
    parameter int LEN = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] dout
);
    generate
        if (LEN == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic signed [DW-1:0] stage [LEN];

            // Shift one position per accepted sample.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < LEN; i++) stage[i] <= '0;
                end else if (en) begin
                    stage[0] <= din;
                    for (int i = 1; i < LEN; i++) stage[i] <= stage[i-1];
                end
            end

            assign dout = stage[LEN-1];
        end
    endgenerate
endmodule

// File: rtl/lms_xwin.sv
// Input history window. Slice i of win holds x(n-i), where slice 0 is the
// present input. Only LEN-1 older samples are stored. Assumes LEN >= 1.
module lms_xwin #(
    parameter int DW  = 16,
    parameter int LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] din,
    output logic [LEN*DW-1:0]    win
);
    assign win[DW-1:0] = din;

    generate
        if (LEN > 1) begin : g_hist
            logic [DW-1:0] hist [LEN-1];

            // Advance the history on each accepted sample.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < LEN - 1; i++) hist[i] <= '0;
                end else if (en) begin
                    hist[0] <= din;
                    for (int i = 1; i < LEN - 1; i++) hist[i] <= hist[i-1];
                end
            end

            for (genvar i = 1; i < LEN; i++) begin : g_slice
                assign win[i*DW +: DW] = hist[i-1];
            end
        end
    endgenerate
endmodule

// File: rtl/lms_coef_bank.sv
// Coefficient store with saturating LMS update, one lane per tap.
// Assumes err and the per-tap update inputs are already aligned by the
// caller to the chosen adaptation and holdup delays.
module lms_coef_bank #(
    parameter int DW       = 16,
    parameter int AW       = 24,
    parameter int TAPS     = 8,
    parameter int MU_SHIFT = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] err,
    input  logic [TAPS*DW-1:0]   x_upd,
    output logic [TAPS*AW-1:0]   coef_flat
);
    import lms_pkg::*;

    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_tap
            logic signed [DW-1:0] xu;
            logic signed [AW-1:0] c;
            longint               step;
            longint               nxt;

            assign xu = signed'(x_upd[k*DW +: DW]);

            // Scaled correction and clamped next value for this tap.
            always_comb begin
                step = (longint'(err) * longint'(xu)) >>> MU_SHIFT;
                nxt  = clip(longint'(c) + step, AW);
            end

            // Coefficient register: zero on reset, updated per sample.
            always_ff @(posedge clk) begin
                if (!rst_n)  c <= '0;
                else if (en) c <= AW'(nxt);
            end

            assign coef_flat[k*AW +: AW] = c;
        end
    endgenerate
endmodule

// File: rtl/lms_dlms.sv
// Delayed-update LMS adaptive FIR filter, one sample per strobe.
// Output y and error e are registered and flagged by out_valid.
// Assumes TAPS >= 1, DW and AW <= 31, and CFRAC < AW + DW.
module lms_dlms #(
    parameter int DW        = 16,
    parameter int AW        = 24,
    parameter int CFRAC     = 20,
    parameter int TAPS      = 8,
    parameter int MU_SHIFT  = 12,
    parameter int ADAPT_DLY = 2,
    parameter int HOLD_DLY  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] x_in,
    input  logic signed [DW-1:0] d_in,
    output logic signed [DW-1:0] y_out,
    output logic signed [DW-1:0] e_out,
    output logic                 out_valid
);
    import lms_pkg::*;

    localparam int WIN = HOLD_DLY + ADAPT_DLY + TAPS;

    logic [WIN*DW-1:0]    x_win;
    logic [TAPS*DW-1:0]   x_filt;
    logic [TAPS*DW-1:0]   x_upd;
    logic [TAPS*AW-1:0]   coef_flat;
    logic signed [DW-1:0] d_hold;
    logic signed [DW-1:0] err_dly;
    logic signed [DW-1:0] y_now;
    logic signed [DW-1:0] e_now;
    longint               acc_sum;

    lms_xwin #(.DW(DW), .LEN(WIN)) u_xwin (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .din(x_in), .win(x_win)
    );

    lms_delay_line #(.DW(DW), .LEN(HOLD_DLY)) u_dhold (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .din(d_in), .dout(d_hold)
    );

    lms_delay_line #(.DW(DW), .LEN(ADAPT_DLY)) u_edly (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .din(e_now), .dout(err_dly)
    );

    // Filter taps sit past the holdup; update taps also past the adaptation delay.
    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_sel
            assign x_filt[k*DW +: DW] = x_win[(HOLD_DLY + k)*DW +: DW];
            assign x_upd[k*DW +: DW]  = x_win[(HOLD_DLY + ADAPT_DLY + k)*DW +: DW];
        end
    endgenerate

    lms_coef_bank #(.DW(DW), .AW(AW), .TAPS(TAPS), .MU_SHIFT(MU_SHIFT)) u_coef (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .err(err_dly),
        .x_upd(x_upd), .coef_flat(coef_flat)
    );

    // Inner product, rescale to data format, then error against held desired.
    always_comb begin
        acc_sum = 0;
        for (int k = 0; k < TAPS; k++) begin
            acc_sum = acc_sum + longint'(signed'(coef_flat[k*AW +: AW]))
                              * longint'(signed'(x_filt[k*DW +: DW]));
        end
        y_now = DW'(clip(acc_sum >>> CFRAC, DW));
        e_now = DW'(clip(longint'(d_hold) - longint'(y_now), DW));
    end

    // Output registers and their strobe flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_out     <= '0;
            e_out     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                y_out <= y_now;
                e_out <= e_now;
            end
        end
    end
endmodule

// File: rtl/lms_dlms_chk.sv
// Property checker for lms_dlms, attached by bind below.
// Assumes reset is held for at least one clock edge at start-up.
module lms_dlms_chk #(
    parameter int DW   = 16,
    parameter int AW   = 24,
    parameter int TAPS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic signed [DW-1:0] y_out,
    input logic signed [DW-1:0] e_out,
    input logic                 out_valid,
    input logic signed [DW-1:0] d_hold,
    input logic signed [DW-1:0] err_dly,
    input logic [TAPS*AW-1:0]   coef_flat
);
    import lms_pkg::*;

    // R8: an accepted sample raises the flag on the next cycle.
    p_flag_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8: no strobe, no flag.
    p_flag_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6: idle cycles freeze outputs and coefficients.
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(y_out) && $stable(e_out) && $stable(coef_flat)));

    // R3: the registered error matches the desired sample held last cycle.
    p_err_relation_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (longint'(e_out) == clip(longint'($past(d_hold)) - longint'(y_out), DW)));

    // R4: a zero delayed error leaves every coefficient untouched.
    p_zero_err_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && err_dly == '0) |=> $stable(coef_flat));
endmodule

bind lms_dlms lms_dlms_chk #(.DW(DW), .AW(AW), .TAPS(TAPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .y_out(y_out),
    .e_out(e_out), .out_valid(out_valid), .d_hold(d_hold),
    .err_dly(err_dly), .coef_flat(coef_flat)
);

// File: tb/tb_lms_dlms.sv
// Directed bench: two instances (delayed and plain LMS) checked against a
// bench model built from the requirements.
module tb_lms_dlms;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 12;
    localparam int AW    = 14;
    localparam int CFRAC = 10;
    localparam int TAPS  = 4;
    localparam int MU    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] x_in = '0;
    logic signed [DW-1:0] d_in = '0;
    logic signed [DW-1:0] y0, e0, y1, e1;
    logic v0, v1;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lms_dlms #(.DW(DW), .AW(AW), .CFRAC(CFRAC), .TAPS(TAPS), .MU_SHIFT(MU),
               .ADAPT_DLY(2), .HOLD_DLY(1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in), .d_in(d_in),
        .y_out(y0), .e_out(e0), .out_valid(v0));

    lms_dlms #(.DW(DW), .AW(AW), .CFRAC(CFRAC), .TAPS(TAPS), .MU_SHIFT(MU),
               .ADAPT_DLY(0), .HOLD_DLY(0)) dut_lms (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in), .d_in(d_in),
        .y_out(y1), .e_out(e1), .out_valid(v1));

    // Bench model state: index 0 mirrors dut, index 1 mirrors dut_lms.
    int     m_ad [2] = '{2, 0};
    int     m_hd [2] = '{1, 0};
    longint m_c  [2][TAPS];
    longint m_x  [2][16];
    longint m_e  [2][16];
    longint m_d  [2][16];
    longint ey [2], ee [2];
    longint ly0, le0, ly1, le1;
    bit     have_exp = 0;
    logic [15:0] lf = 16'hACE1;
    longint px1 = 0, px2 = 0;

    function automatic longint sat(longint v, int w);
        longint hi = (longint'(1) <<< (w - 1)) - 1;
        if (v > hi) return hi;
        if (v < -hi - 1) return -hi - 1;
        return v;
    endfunction

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < TAPS; k++) m_c[m][k] = 0;
            for (int i = 0; i < 16; i++) begin
                m_x[m][i] = 0; m_e[m][i] = 0; m_d[m][i] = 0;
            end
        end
        px1 = 0; px2 = 0;
    endtask

    task automatic model_step(int m, longint x, longint d);
        longint s = 0;
        for (int i = 15; i > 0; i--) begin
            m_x[m][i] = m_x[m][i-1]; m_d[m][i] = m_d[m][i-1]; m_e[m][i] = m_e[m][i-1];
        end
        m_x[m][0] = x; m_d[m][0] = d;
        for (int k = 0; k < TAPS; k++) s += m_c[m][k] * m_x[m][k + m_hd[m]];
        ey[m] = sat(s >>> CFRAC, DW);
        ee[m] = sat(m_d[m][m_hd[m]] - ey[m], DW);
        m_e[m][0] = ee[m];
        for (int k = 0; k < TAPS; k++)
            m_c[m][k] = sat(m_c[m][k] +
                ((m_e[m][m_ad[m]] * m_x[m][k + m_ad[m] + m_hd[m]]) >>> MU), AW);
    endtask

    task automatic check(string req, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_outputs();
        check("R8 valid flag", v0, 1);
        check("R2 R4 y delayed", y0, ey[0]);
        check("R3 e delayed", e0, ee[0]);
        check("R7 y plain", y1, ey[1]);
        check("R7 e plain", e1, ee[1]);
        ly0 = y0; le0 = e0; ly1 = y1; le1 = e1;
    endtask

    // kind 0: random input into a fixed plant; 1: saturating drive; 2: alternating
    task automatic burst(int n, int kind);
        longint x, d;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (have_exp) check_outputs();
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (kind == 0) begin
                x = longint'(signed'(lf[9:0]));
                d = (3*x - 2*px1 + px2) >>> 2;
            end else if (kind == 1) begin
                x = 1; d = 2047;
            end else begin
                x = (i % 2 == 0) ? 300 : -300;
                d = -x;
            end
            px2 = px1; px1 = x;
            x_in = DW'(x); d_in = DW'(d); in_valid = 1'b1;
            model_step(0, x, d);
            model_step(1, x, d);
            have_exp = 1;
        end
        @(negedge clk);
        check_outputs();
        in_valid = 1'b0;
        have_exp = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check("R1 y reset", y0, 0);
        check("R1 e reset", e0, 0);
        check("R1 valid reset", v0, 0);
        check("R1 plain y reset", y1, 0);
    endtask

    task automatic t_gap();
        for (int i = 0; i < 6; i++) begin
            x_in = DW'(400 - 37*i); d_in = DW'(-250 + 91*i);
            @(negedge clk);
            check("R8 idle flag", v0, 0);
            check("R6 y hold", y0, ly0);
            check("R6 e hold", e0, le0);
            check("R6 plain y hold", y1, ly1);
        end
    endtask

    task automatic t_saturate();
        burst(120, 1);
        check("R5 y at coef bound", ly0, 31);
        check("R5 plain y at coef bound", ly1, 31);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        t_reset();
        burst(1, 0);      // R1: first post-reset output is zero
        burst(200, 0);
        t_gap();
        burst(100, 0);    // resumes on unchanged coefficients (R6)
        burst(40, 2);
        t_reset();
        t_saturate();
        t_reset();
        burst(50, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule